// File: doc/BRIEF.md
# Latching Level-Event Interrupt Bank

This block watches a set of external event lines, such as power-loss or brown-out indications, and records each event in a sticky flag. A flag is set directly by the level of its input, through an asynchronous set path, so an event is caught even while the bus clock is stopped. Software reads the flags through a small register port, acknowledges them with write-one-to-clear, and receives one combined interrupt line.

Each channel has its own enable bit and polarity bit. Polarity 0 treats a high input as active, and polarity 1 treats a low input as active. Only level detection exists. Software can still get edge behaviour by flipping the polarity after each event. A flag crosses into the bus clock domain through a two-stage synchronizer before any read or the interrupt can see it. The mode register is kept in the address map but always reads level mode (zero).

Top module: `evt_latch_bank`

## Requirements
- R1: After reset, with every input inactive, the enable (0x00), polarity (0x10), raw status (0x04) and masked status (0x08) registers read 0, and `irq` is low.
- R2: An input that reaches its active level sets its flag. The flag stays set after the input returns to inactive. It shows in raw status (0x04, bit n = channel n) no later than three bus clock edges later.
- R3: A pulse on an input while the bus clock is stopped is still recorded, and it shows in raw status once the clock runs again.
- R4: Polarity bit n (0x10) selects the active level of channel n: 0 means high is active, 1 means low is active. A level that is inactive under the chosen polarity sets nothing.
- R5: Writing the clear register (0x0C) clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R6: If an input is still at its active level when its flag is cleared, the flag is set again at once and raw status still reports it.
- R7: Masked status (0x08) equals raw status AND the enable register. Raw status reports channels regardless of their enable bit.
- R8: `irq` is high exactly when masked status is nonzero, and it follows enable writes on the next clock edge.
- R9: The enable and polarity registers read back the value written. The mode register (0x14) always reads 0, and writes to it are ignored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; may be stopped while events are still captured |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 8 | Asynchronous event level inputs, one per channel |
| reg_wr | input | 1 | Register write strobe, sampled on the clock edge |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 8 | Write data, bit n for channel n |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | OR of the masked status bits |

## Verification
The assertions take each event line as stable across a clock sample. An input that rises exactly at a clock edge could be seen as active before its flag has set. They also take reset as lasting long enough to flush the synchronizer. The bench changes `evt_in`, and starts or stops the clock, only at falling edges or in the middle of a half-period. It holds reset for several cycles with every input inactive, and it waits three clock edges after each event or clear before it compares status.

// File: rtl/evt_latch_pkg.sv
// Package: shared geometry and register addresses of the level-event bank.
// Assumes byte addressing with one register per 4-byte slot.
package evt_latch_pkg;
    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_ENABLE = 5'h00;
    localparam logic [ADDR_W-1:0] A_RAW    = 5'h04;
    localparam logic [ADDR_W-1:0] A_MASKED = 5'h08;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_POLAR  = 5'h10;
    localparam logic [ADDR_W-1:0] A_MODE   = 5'h14;
endpackage

// File: rtl/evt_capture_cell.sv
// Module: one sticky event flag.
// Sets asynchronously while the input is at its active level, with no clock
// needed. Clears synchronously on reset or on a clear pulse. The set path has
// priority, so a flag cleared while its input is still active stays set.
// Assumes clr is a single-cycle pulse from the bus clock domain.
module evt_capture_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic active_low,
    input  logic clr,
    output logic flag
);
    logic arm;

    // Active level detect: polarity 0 means high is active.
    assign arm = level_in ^ active_low;

    // Sticky flag: asynchronous set by level, synchronous reset and clear.
    always_ff @(posedge clk or posedge arm) begin
        if (arm)
            flag <= 1'b1;
        else if (!rst_n)
            flag <= 1'b0;
        else if (clr)
            flag <= 1'b0;
    end

    // R2: an active level seen at a clock edge always has its flag set.
    a_r2_level_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> flag);

    // R5: without a clear pulse a set flag stays set.
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R6: a clear while the level is still active leaves the flag set.
    a_r6_rearm_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && arm) |=> flag);
endmodule

// File: rtl/evt_sync2.sv
// Module: two-flop synchronizer, one per bit, into the bus clock domain.
// Assumes each bit is an independent flag; no bus coherency is implied.
module evt_sync2 #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Two-stage capture of the asynchronous flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/evt_regs.sv
// Module: register file and read decode of the event bank.
// Holds the enable and polarity registers, turns writes to the clear address
// into a one-cycle clear vector, and returns read data combinationally.
// Assumes reg_addr is stable while reg_rdata is sampled.
module evt_regs
    import evt_latch_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NCH-1:0]    reg_wdata,
    input  logic [NCH-1:0]    raw_sync,
    output logic [NCH-1:0]    en_q,
    output logic [NCH-1:0]    pol_q,
    output logic [NCH-1:0]    clr_vec,
    output logic [NCH-1:0]    reg_rdata
);
    logic wr_en, wr_pol, wr_clr;

    // Address decode of the write strobe.
    always_comb begin
        wr_en  = reg_wr && (reg_addr == A_ENABLE);
        wr_pol = reg_wr && (reg_addr == A_POLAR);
        wr_clr = reg_wr && (reg_addr == A_CLEAR);
    end

    // Write-one-to-clear pulse, valid for the write cycle only.
    assign clr_vec = wr_clr ? reg_wdata : '0;

    // Enable and polarity storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else begin
            if (wr_en)  en_q  <= reg_wdata;
            if (wr_pol) pol_q <= reg_wdata;
        end
    end

    // Read mux; the mode register is fixed at level mode (zero).
    always_comb begin
        case (reg_addr)
            A_ENABLE: reg_rdata = en_q;
            A_RAW:    reg_rdata = raw_sync;
            A_MASKED: reg_rdata = raw_sync & en_q;
            A_POLAR:  reg_rdata = pol_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R9: the enable register changes only on a write to its own address.
    a_r9_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_ENABLE) |=> $stable(en_q));

    // R9: the polarity register changes only on a write to its own address.
    a_r9_polarity_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_POLAR) |=> $stable(pol_q));
endmodule

// File: rtl/evt_latch_bank.sv
// Module: top of the latching level-event interrupt bank.
// One capture cell per channel, a synchronizer into the bus domain, the
// register file, and the combined interrupt. Assumes evt_in may change at any
// time, including while clk is stopped.
module evt_latch_bank
    import evt_latch_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    evt_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NCH-1:0]    reg_wdata,
    output logic [NCH-1:0]    reg_rdata,
    output logic              irq
);
    logic [NCH-1:0] flags;
    logic [NCH-1:0] raw_sync;
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] pol_q;
    logic [NCH-1:0] clr_vec;

    // Per-channel sticky capture.
    for (genvar g = 0; g < NCH; g++) begin : g_cell
        evt_capture_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_in   (evt_in[g]),
            .active_low (pol_q[g]),
            .clr        (clr_vec[g]),
            .flag       (flags[g])
        );
    end

    evt_sync2 #(.W(NCH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (flags),
        .sync_out (raw_sync)
    );

    evt_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw_sync  (raw_sync),
        .en_q      (en_q),
        .pol_q     (pol_q),
        .clr_vec   (clr_vec),
        .reg_rdata (reg_rdata)
    );

    // Combined interrupt from the enabled, synchronized flags.
    assign irq = |(raw_sync & en_q);

    // R2: synchronized status reports only flags that were set two edges back.
    a_r2_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_sync & ~$past(flags, 2)) == '0);

    // R8: the interrupt never fires with every channel disabled.
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_q != '0));

    // R7: the interrupt never fires without a synchronized flag.
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_sync != '0));
endmodule

// File: tb/sim_evt_latch_bank.sv
module sim_evt_latch_bank;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic [7:0] evt_in = '0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    evt_latch_bank u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    // 250 MHz clock that can be held low.
    initial forever begin
        #2;
        if (clk_run) clk = ~clk;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(5'h00, v); chk("R1 enable", v, 8'h00);
        rd(5'h10, v); chk("R1 polarity", v, 8'h00);
        rd(5'h04, v); chk("R1 raw", v, 8'h00);
        rd(5'h08, v); chk("R1 masked", v, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_capture;
        logic [7:0] v;
        @(negedge clk); evt_in = 8'h42;
        @(negedge clk); evt_in = 8'h00;
        cyc(3);
        rd(5'h04, v); chk("R2 sticky capture", v, 8'h42);
        wr(5'h0C, 8'hFF); cyc(3);
        rd(5'h04, v); chk("R2 cleared", v, 8'h00);
    endtask

    task automatic t_noclock;
        logic [7:0] v;
        @(negedge clk);
        clk_run = 1'b0;
        #10 evt_in[5] = 1'b1;
        #10 evt_in[5] = 1'b0;
        #10 clk_run = 1'b1;
        cyc(3);
        rd(5'h04, v); chk("R3 capture without clock", v, 8'h20);
        wr(5'h0C, 8'h20); cyc(3);
    endtask

    task automatic t_polarity;
        logic [7:0] v;
        @(negedge clk); evt_in[2] = 1'b1;
        wr(5'h10, 8'h04);
        wr(5'h0C, 8'h04); cyc(3);
        rd(5'h04, v); chk("R4 high ignored when active-low", v, 8'h00);
        rd(5'h10, v); chk("R9 polarity readback", v, 8'h04);
        @(negedge clk); evt_in[2] = 1'b0;
        cyc(3);
        rd(5'h04, v); chk("R4 low captured when active-low", v, 8'h04);
        @(negedge clk); evt_in[2] = 1'b1;
        wr(5'h10, 8'h00);
        @(negedge clk); evt_in[2] = 1'b0;
        wr(5'h0C, 8'hFF); cyc(3);
        rd(5'h04, v); chk("R4 restored", v, 8'h00);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        @(negedge clk); evt_in = 8'h81;
        @(negedge clk); evt_in = 8'h00;
        wr(5'h0C, 8'h80); cyc(3);
        rd(5'h04, v); chk("R5 partial clear", v, 8'h01);
        wr(5'h0C, 8'h01); cyc(3);
        rd(5'h04, v); chk("R5 full clear", v, 8'h00);
    endtask

    task automatic t_rearm;
        logic [7:0] v;
        @(negedge clk); evt_in[3] = 1'b1;
        cyc(3);
        wr(5'h0C, 8'h08); cyc(3);
        rd(5'h04, v); chk("R6 still active after clear", v, 8'h08);
        @(negedge clk); evt_in[3] = 1'b0;
        wr(5'h0C, 8'h08); cyc(3);
        rd(5'h04, v); chk("R6 clear after release", v, 8'h00);
    endtask

    task automatic t_mask_irq;
        logic [7:0] v;
        @(negedge clk); evt_in = 8'h42;
        @(negedge clk); evt_in = 8'h00;
        cyc(3);
        chk("R8 irq low while disabled", {7'b0, irq}, 8'h00);
        wr(5'h00, 8'h02);
        rd(5'h08, v); chk("R7 masked", v, 8'h02);
        rd(5'h04, v); chk("R7 raw ignores enable", v, 8'h42);
        rd(5'h00, v); chk("R9 enable readback", v, 8'h02);
        chk("R8 irq high", {7'b0, irq}, 8'h01);
        wr(5'h00, 8'h04);
        rd(5'h08, v); chk("R7 masked other channel", v, 8'h00);
        chk("R8 irq low after disable", {7'b0, irq}, 8'h00);
        wr(5'h0C, 8'hFF); cyc(3);
        wr(5'h00, 8'h00);
    endtask

    task automatic t_mode;
        logic [7:0] v;
        wr(5'h14, 8'hFF);
        rd(5'h14, v); chk("R9 mode reads zero", v, 8'h00);
        rd(5'h18, v); chk("R9 unmapped reads zero", v, 8'h00);
        rd(5'h00, v); chk("R9 enable untouched by mode write", v, 8'h00);
        rd(5'h10, v); chk("R9 polarity untouched by mode write", v, 8'h00);
    endtask

    initial begin
        cyc(5);
        @(negedge clk); rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_capture();
        t_noclock();
        t_polarity();
        t_clear();
        t_rearm();
        t_mask_irq();
        t_mode();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            #(200000 * 4);
        join_any
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule